// File: doc/BRIEF.md
# Split-Bank Video Memory Arbiter

This block holds a byte-addressed video memory in two separate RAMs. One RAM keeps the bytes at even addresses and the other keeps the bytes at odd addresses. The display side gives a cell index and receives the cell's code byte (even) and attribute byte (odd) together, one cycle later. The CPU side sees one flat byte space. The address LSB picks the RAM, and the remaining bits form the word address inside that RAM.

Both sides share the single address port of each RAM, so only one of them can use it in a cycle. A mode input sets who wins:

- In slow mode the CPU is held off with `cpu_wait` while the display is fetching.
- In fast mode the CPU always wins at once. The display fetch of that cycle is lost, and the lost fetch is flagged by a low `vid_valid`.

A request that is waiting keeps the mode it started with.

Top module: `vram_split`

## Requirements
- R1: The CPU sees 2^ADDR_W bytes (2048 by default). A byte written at any address is returned by a later CPU read of that address.
- R2: A display fetch of cell k with `vid_req` high returns byte 2k on `vid_even` and byte 2k+1 on `vid_odd` one cycle later, with `vid_valid` high, when no CPU access is granted in the fetch cycle.
- R3: A granted CPU read puts the byte on `cpu_rdata` one cycle after the grant, and `cpu_rvalid` is high for that one cycle. Writes do not raise `cpu_rvalid`.
- R4: In slow mode (`slow_mode`=1), `cpu_wait` is high while `cpu_req` and `vid_req` are both high. The access is granted in the first cycle in which `vid_req` is low, and a held write lands exactly once.
- R5: In fast mode (`slow_mode`=0), `cpu_wait` never rises. If `vid_req` is high in the cycle of a CPU grant, `vid_valid` is low in the next cycle.
- R6: A change of `slow_mode` while a request is waiting has no effect on that request. The new mode applies from the next access onward.
- R7: After reset, `vid_valid`, `cpu_rvalid` and `cpu_wait` are low while no requests are made.
- R8: A CPU write changes only the bank picked by its address LSB. The byte at the neighbouring address of the same cell is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | 1: CPU yields to display; 0: CPU preempts display |
| cpu_req | input | 1 | CPU access request, held until `cpu_wait` is low |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | DATA_W | CPU write byte |
| cpu_rdata | output | DATA_W | CPU read byte, valid with `cpu_rvalid` |
| cpu_rvalid | output | 1 | Read data strobe, one cycle after grant |
| cpu_wait | output | 1 | CPU request not granted this cycle |
| vid_req | input | 1 | Display fetch request |
| vid_addr | input | ADDR_W-1 | Display cell index |
| vid_even | output | DATA_W | Code byte of the fetched cell |
| vid_odd | output | DATA_W | Attribute byte of the fetched cell |
| vid_valid | output | 1 | Fetch result is undisturbed |

## Verification
The assertions assume that the CPU holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady while `cpu_wait` is high, and that reads and writes come only from requests. The bench drives every CPU access through one task or one hand-stepped sequence. Each of these keeps the request fields unchanged until the grant cycle and drops `cpu_req` straight after it. Display requests change only at falling clock edges, and so does `slow_mode`, which the mode test flips in the middle of a wait.

// File: rtl/vram_split.sv
module vram_split #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic              cpu_wait,
  input  logic              vid_req,
  input  logic [ADDR_W-2:0] vid_addr,
  output logic [DATA_W-1:0] vid_even,
  output logic [DATA_W-1:0] vid_odd,
  output logic              vid_valid
);
  localparam int BANK_W = ADDR_W - 1;
  localparam int DEPTH  = 1 << BANK_W;

  logic [DATA_W-1:0] ev_mem [DEPTH];
  logic [DATA_W-1:0] od_mem [DEPTH];
  logic [DATA_W-1:0] ev_q, od_q;
  logic [BANK_W-1:0] bank_addr;
  logic grant, eff_slow, held_q, mode_q, lsb_q, rvalid_q, vvalid_q;

  assign eff_slow  = held_q ? mode_q : slow_mode;
  assign grant     = cpu_req & ~(eff_slow & vid_req);
  assign cpu_wait  = cpu_req & ~grant;
  assign bank_addr = grant ? cpu_addr[ADDR_W-1:1] : vid_addr;

  always_ff @(posedge clk) begin
    if (grant && cpu_we && !cpu_addr[0]) ev_mem[bank_addr] <= cpu_wdata;
    if (grant && cpu_we &&  cpu_addr[0]) od_mem[bank_addr] <= cpu_wdata;
    ev_q <= ev_mem[bank_addr];
    od_q <= od_mem[bank_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      mode_q   <= 1'b0;
      lsb_q    <= 1'b0;
      rvalid_q <= 1'b0;
      vvalid_q <= 1'b0;
    end else begin
      held_q   <= cpu_wait;
      mode_q   <= eff_slow;
      lsb_q    <= cpu_addr[0];
      rvalid_q <= grant & ~cpu_we;
      vvalid_q <= vid_req & ~grant;
    end
  end

  assign cpu_rdata  = lsb_q ? od_q : ev_q;
  assign cpu_rvalid = rvalid_q;
  assign vid_even   = ev_q;
  assign vid_odd    = od_q;
  assign vid_valid  = vvalid_q;

  a_r4_wait_means_video: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> (vid_req && eff_slow));
  a_r4_hold_while_video: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && vid_req && eff_slow) |-> cpu_wait);
  a_r5_fast_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !eff_slow) |-> !cpu_wait);
  a_r5_stolen_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && cpu_req && !cpu_wait) |=> !vid_valid);
  a_r2_clean_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && !cpu_req) |=> vid_valid);
  a_r3_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !cpu_wait) |=> cpu_rvalid);
  a_r3_no_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req || cpu_we || cpu_wait) |=> !cpu_rvalid);
  a_r6_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |=> (eff_slow == $past(eff_slow)));
endmodule

// File: tb/vram_split_bench.sv
module vram_split_bench;
  localparam int AW = 11;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_mode = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0, vid_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [AW-2:0] vid_addr = '0;
  logic [7:0] cpu_rdata, vid_even, vid_odd;
  logic cpu_rvalid, cpu_wait, vid_valid;
  logic [7:0] exp_mem [N];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vram_split #(.ADDR_W(AW), .DATA_W(8)) u_vram_split (
    .clk, .rst_n, .slow_mode, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_rdata, .cpu_rvalid, .cpu_wait, .vid_req, .vid_addr,
    .vid_even, .vid_odd, .vid_valid);

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + (a >> 4)) ^ 8'h5A);
  endfunction

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic cpu_acc(input logic we, input int a, input logic [7:0] d,
                         output logic [7:0] rd, output logic rv);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = d;
    #1;
    while (cpu_wait) begin @(negedge clk); #1; end
    @(negedge clk);
    rd = cpu_rdata; rv = cpu_rvalid;
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (we) exp_mem[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic rv;
    repeat (3) @(negedge clk);
    chk("R7 vid_valid", vid_valid, 0);
    chk("R7 cpu_rvalid", cpu_rvalid, 0);
    chk("R7 cpu_wait", cpu_wait, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 vid_valid idle", vid_valid, 0);

    for (int a = 0; a < N; a++) begin
      cpu_acc(1'b1, a, pat(a), rd, rv);
      if (a == 0) chk("R3 write no rvalid", rv, 0);
    end
    for (int a = 0; a < N; a++) begin
      cpu_acc(1'b0, a, 8'h00, rd, rv);
      chk("R1 readback", rd, exp_mem[a]);
      chk("R3 rvalid", rv, 1);
    end
    @(negedge clk);
    chk("R3 rvalid single", cpu_rvalid, 0);

    for (int k = 0; k <= N / 2; k++) begin
      if (k < N / 2) begin vid_req = 1'b1; vid_addr = (AW-1)'(k); end
      else vid_req = 1'b0;
      @(negedge clk);
      if (k < N / 2) begin
        chk("R2 valid", vid_valid, 1);
        chk("R2 even", vid_even, exp_mem[2*k]);
        chk("R2 odd", vid_odd, exp_mem[2*k+1]);
      end
    end

    cpu_acc(1'b1, 5, 8'hE7, rd, rv);
    vid_req = 1'b1; vid_addr = 2;
    @(negedge clk); vid_req = 1'b0;
    chk("R8 odd written", vid_odd, 8'hE7);
    chk("R8 even untouched", vid_even, exp_mem[4]);
    cpu_acc(1'b1, 8, 8'h3C, rd, rv);
    cpu_acc(1'b0, 9, 8'h00, rd, rv);
    chk("R8 odd untouched", rd, exp_mem[9]);

    slow_mode = 1'b1; vid_req = 1'b1; vid_addr = 0;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 9; cpu_wdata = 8'hC3;
    #1 chk("R4 wait raised", cpu_wait, 1);
    @(negedge clk);
    chk("R4 display kept", vid_valid, 1);
    chk("R4 display even", vid_even, exp_mem[0]);
    #1 chk("R4 still waiting", cpu_wait, 1);
    @(negedge clk); vid_req = 1'b0;
    #1 chk("R4 granted when idle", cpu_wait, 0);
    @(negedge clk); cpu_req = 1'b0; cpu_we = 1'b0; exp_mem[9] = 8'hC3;
    cpu_acc(1'b0, 9, 8'h00, rd, rv);
    chk("R4 write landed", rd, 8'hC3);

    vid_req = 1'b1; vid_addr = 1;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 3;
    #1 chk("R6 wait start", cpu_wait, 1);
    @(negedge clk); slow_mode = 1'b0;
    #1 chk("R6 mode kept while waiting", cpu_wait, 1);
    @(negedge clk); vid_req = 1'b0;
    #1 chk("R6 granted", cpu_wait, 0);
    @(negedge clk); cpu_req = 1'b0;
    chk("R6 rvalid", cpu_rvalid, 1);
    chk("R6 rdata", cpu_rdata, exp_mem[3]);

    vid_req = 1'b1; vid_addr = 10;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 6;
    #1 chk("R5 no wait", cpu_wait, 0);
    @(negedge clk); cpu_req = 1'b0;
    chk("R5 stolen flagged", vid_valid, 0);
    chk("R5 read ok", cpu_rdata, exp_mem[6]);
    chk("R6 new mode applied rvalid", cpu_rvalid, 1);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 20; cpu_wdata = 8'h11;
    #1 chk("R5 write no wait", cpu_wait, 0);
    @(negedge clk); cpu_req = 1'b0; cpu_we = 1'b0; exp_mem[20] = 8'h11;
    chk("R5 write stolen flagged", vid_valid, 0);
    @(negedge clk);
    chk("R5 display resumes", vid_valid, 1);
    chk("R2 even after steal", vid_even, exp_mem[20]);
    vid_req = 1'b0;
    cpu_acc(1'b0, 20, 8'h00, rd, rv);
    chk("R5 fast write landed", rd, 8'h11);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule